// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a controller and a byte-wide parallel flash device. A request names one operation, a target offset and, for page writes, a byte count. The block turns that request into the unlock-prefixed write sequence the device expects. It inserts settling gaps or fixed waits where the operation needs them. It then polls the device's toggling status bit until the internal operation ends.

Programming operations take their data from a byte stream with a valid/ready handshake and hold it in a small local buffer. Data bytes equal to 0xFF are never put on the bus, because an erased cell already holds that value. After each program attempt the block reads the written bytes back. On a mismatch it repeats the whole attempt, up to a bounded number of extra tries, and then gives up and reports failure.

Every bus address is a parameterised base address plus either a fixed command offset or the request's target offset. The controller sees a busy level, a one-cycle done pulse and a fail flag. The fail flag stays set until the next accepted request.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is active, and in the first idle cycle after it, `busy`, `done`, `fail`, `fl_we`, `fl_re` and `src_ready` are all low.
- R2: `req_op` codes are 0 sector erase, 1 block erase, 2 chip erase, 3 byte program, 4 page program, 5 protect and 6 unprotect. The block refuses code 7, and it refuses a page program whose `req_len` is 0 or greater than PAGE_MAX. A refused request leaves `busy` low and changes no state.
- R3: A request is taken only when the block is idle. `busy` rises in the cycle after acceptance and stays high up to and including the `done` cycle. A request that is held valid while busy has no effect on the bus until the block returns to idle.
- R4: Each erase writes six bytes in order: AA@BASE+0x5555, 55@BASE+0x2AAA, 80@BASE+0x5555, AA@BASE+0x5555, 55@BASE+0x2AAA. The last write is then one of: 30 at BASE+target (sector), 50 at BASE+target (block), or 10 at BASE+0x5555 (chip).
- R5: During an erase, exactly GAP_CYC cycles with no bus strobe lie between consecutive writes. The first status read comes GAP_CYC+1 cycles after the final erase write.
- R6: Completion is detected when two successive status reads agree in bit 6. Erases poll at BASE and programs poll at the request's last byte address. If POLL_MAX reads pass without agreement, the operation ends with `fail` set.
- R7: Protect writes AA@0x5555, 55@0x2AAA and A0@0x5555 (plus BASE). Unprotect writes the six-byte erase prefix with the last byte 20@BASE+0x5555. Both issue no reads, and `done` follows the last write by exactly PROT_CYC+1 cycles.
- R8: Byte program writes the three-byte A0 prefix and then the data byte at BASE+target. A data byte of 0xFF puts nothing on the bus, and the block finishes without failure.
- R9: Page program issues one A0 prefix and then writes the non-0xFF bytes in stream order. Byte i goes to BASE+target+i, and 0xFF bytes are skipped.
- R10: After the toggle wait, each programmed byte is read back and compared. On a mismatch the whole prefix-and-data sequence is repeated, at most MAX_RETRY times. After that the block sets `fail`.
- R11: `done` is a one-cycle pulse per accepted request. `fail` keeps its value until the next accepted request clears it. A refused request does not clear it.
- R12: `src_ready` is high only while a programming request is collecting data. Exactly `req_len` bytes are taken for a page and one byte for a byte program, each on a cycle where `src_valid` and `src_ready` are both high.
- R13: `fl_rdata` is sampled in the cycle after `fl_re` is high, and `fl_we` and `fl_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Target offset from BASE |
| req_len | input | LENW | Page byte count |
| src_valid | input | 1 | Source byte present |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Source byte taken when valid is also high |
| fl_we | output | 1 | Flash write strobe, one cycle per byte |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last operation failed |

## Verification
The completion pulse and the acceptance of the next request meet at the same boundary. In the `done` cycle the block is still busy, so a request offered then must be refused and taken one cycle later. The bench provokes this by holding a protect request valid across a whole protect operation. It then requires exactly one idle cycle after `done`, followed by a second complete three-write sequence. It also requires that no extra bus writes appear while the first sequence runs. A second overlap is the clearing of a sticky `fail` at acceptance. The bench leaves `fail` set by an exhausted retry, offers refused requests that must leave it set, and then checks that an accepted one clears it.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_SECT   = 3'd0,
    OP_BLK    = 3'd1,
    OP_CHIP   = 3'd2,
    OP_BYTE   = 3'd3,
    OP_PAGE   = 3'd4,
    OP_PROT   = 3'd5,
    OP_UNPROT = 3'd6
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_CMD, S_HOLD, S_DATA, S_POLL, S_VRD, S_VCAP, S_FIN
  } st_e;

  localparam logic [15:0] OFS_UNLK_A = 16'h5555;
  localparam logic [15:0] OFS_UNLK_B = 16'h2AAA;
  localparam logic [7:0]  ERASED     = 8'hFF;

  function automatic logic op_is_erase(op_e op);
    return (op == OP_SECT) || (op == OP_BLK) || (op == OP_CHIP);
  endfunction

  function automatic logic op_is_prog(op_e op);
    return (op == OP_BYTE) || (op == OP_PAGE);
  endfunction

  function automatic logic op_short_seq(op_e op);
    return op_is_prog(op) || (op == OP_PROT);
  endfunction

endpackage

// File: rtl/fseq_cmd_table.sv
module fseq_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int          AW   = 20,
  parameter logic [AW-1:0] BASE = '0
) (
  input  op_e           op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt,
  output logic [AW-1:0] addr,
  output logic [7:0]    data,
  output logic          last
);

  localparam logic [AW-1:0] ADDR_A = BASE + AW'(OFS_UNLK_A);
  localparam logic [AW-1:0] ADDR_B = BASE + AW'(OFS_UNLK_B);

  logic short_seq;
  assign short_seq = op_short_seq(op);
  assign last      = short_seq ? (step == 3'd2) : (step == 3'd5);

  always_comb begin
    addr = ADDR_A;
    data = 8'hAA;
    case (step)
      3'd0: begin addr = ADDR_A; data = 8'hAA; end
      3'd1: begin addr = ADDR_B; data = 8'h55; end
      3'd2: begin addr = ADDR_A; data = short_seq ? 8'hA0 : 8'h80; end
      3'd3: begin addr = ADDR_A; data = 8'hAA; end
      3'd4: begin addr = ADDR_B; data = 8'h55; end
      default: begin
        case (op)
          OP_SECT: begin addr = BASE + tgt; data = 8'h30; end
          OP_BLK:  begin addr = BASE + tgt; data = 8'h50; end
          OP_CHIP: begin addr = ADDR_A;     data = 8'h10; end
          default: begin addr = ADDR_A;     data = 8'h20; end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  output logic          last
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = ld || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                cnt_d = ld_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == TW'(1));

endmodule

// File: rtl/fseq_toggle_poll.sv
module fseq_toggle_poll #(
  parameter int AW       = 20,
  parameter int POLL_MAX = 1000000
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic          rd_bit,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          fin,
  output logic          timeout
);

  localparam int PCW = $clog2(POLL_MAX + 1);

  typedef enum logic [1:0] {P_IDLE, P_RD, P_CAP} pst_e;

  pst_e           ps_q, ps_d;
  logic [PCW-1:0] cnt_q, cnt_d;
  logic           prev_q, prev_d, have_q, have_d;
  logic [AW-1:0]  addr_q;
  logic           agree, at_limit;

  assign agree    = have_q && (rd_bit == prev_q);
  assign at_limit = (cnt_q == PCW'(POLL_MAX - 1));

  always_comb begin
    ps_d = ps_q; cnt_d = cnt_q; prev_d = prev_q; have_d = have_q;
    fin = 1'b0; timeout = 1'b0;
    case (ps_q)
      P_IDLE: if (start) begin
        ps_d = P_RD; cnt_d = '0; have_d = 1'b0;
      end
      P_RD: ps_d = P_CAP;
      P_CAP: begin
        if (agree) begin
          fin = 1'b1; ps_d = P_IDLE;
        end else if (at_limit) begin
          fin = 1'b1; timeout = 1'b1; ps_d = P_IDLE;
        end else begin
          prev_d = rd_bit; have_d = 1'b1; cnt_d = cnt_q + PCW'(1); ps_d = P_RD;
        end
      end
      default: ps_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q <= P_IDLE; cnt_q <= '0; prev_q <= 1'b0; have_q <= 1'b0; addr_q <= '0;
    end else begin
      ps_q <= ps_d; cnt_q <= cnt_d; prev_q <= prev_d; have_q <= have_d;
      if (start && ps_q == P_IDLE) addr_q <= addr_in;
    end
  end

  assign rd_en   = (ps_q == P_RD);
  assign rd_addr = addr_q;

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    (ps_q != P_IDLE) |-> (cnt_q < PCW'(POLL_MAX))); // R6

  AST_POLL_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_en |=> (ps_q == P_CAP)); // R13

endmodule

// File: rtl/fseq_page_buf.sv
module fseq_page_buf #(
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int            AW        = 20,
  parameter logic [AW-1:0] BASE      = '0,
  parameter int            PAGE_MAX  = 64,
  parameter int            GAP_CYC   = 2000,
  parameter int            PROT_CYC  = 40000,
  parameter int            POLL_MAX  = 1000000,
  parameter int            MAX_RETRY = 16,
  localparam int           LENW      = $clog2(PAGE_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [LENW-1:0] req_len,
  input  logic            src_valid,
  input  logic [7:0]      src_data,
  output logic            src_ready,
  output logic            fl_we,
  output logic            fl_re,
  output logic [AW-1:0]   fl_addr,
  output logic [7:0]      fl_wdata,
  input  logic [7:0]      fl_rdata,
  output logic            busy,
  output logic            done,
  output logic            fail
);

  localparam int IW   = (PAGE_MAX > 1) ? $clog2(PAGE_MAX) : 1;
  localparam int TMAX = (GAP_CYC > PROT_CYC) ? GAP_CYC : PROT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  st_e            st_q, st_d;
  op_e            op_q, op_d;
  logic [AW-1:0]  tgt_q, tgt_d;
  logic [LENW-1:0] len_q, len_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [2:0]     step_q, step_d;
  logic [RW-1:0]  tries_q, tries_d;
  logic           fail_q, fail_d;

  logic           acc, op_ok, len_ok, last_idx;
  logic [AW-1:0]  tbl_addr, data_addr, poll_addr_in, poll_rd_addr;
  logic [7:0]     tbl_data, buf_rdata;
  logic           tbl_last, buf_we;
  logic           tmr_ld, tmr_last;
  logic [TW-1:0]  tmr_val;
  logic           poll_go, poll_re, poll_fin, poll_to;

  assign op_ok    = (req_op != 3'd7);
  assign len_ok   = (op_e'(req_op) != OP_PAGE) ||
                    ((req_len != '0) && (req_len <= LENW'(PAGE_MAX)));
  assign acc      = (st_q == S_IDLE) && req_valid && op_ok && len_ok;
  assign last_idx = ((LENW'(idx_q) + LENW'(1)) == len_q);
  assign data_addr = BASE + tgt_q + AW'(idx_q);
  assign poll_addr_in = op_is_erase(op_q) ? BASE
                                          : (BASE + tgt_q + AW'(len_q) - AW'(1));

  fseq_cmd_table #(.AW(AW), .BASE(BASE)) u_tbl (
    .op(op_q), .step(step_q), .tgt(tgt_q),
    .addr(tbl_addr), .data(tbl_data), .last(tbl_last)
  );

  fseq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_ni(rst_ni), .ld(tmr_ld), .ld_val(tmr_val), .last(tmr_last)
  );

  fseq_toggle_poll #(.AW(AW), .POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_ni(rst_ni), .start(poll_go), .addr_in(poll_addr_in),
    .rd_bit(fl_rdata[6]), .rd_en(poll_re), .rd_addr(poll_rd_addr),
    .fin(poll_fin), .timeout(poll_to)
  );

  fseq_page_buf #(.DEPTH(PAGE_MAX), .IW(IW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(idx_q), .wdata(src_data),
    .raddr(idx_q), .rdata(buf_rdata)
  );

  // next-state process
  always_comb begin
    st_d = st_q; op_d = op_q; tgt_d = tgt_q; len_d = len_q; idx_d = idx_q;
    step_d = step_q; tries_d = tries_q; fail_d = fail_q;
    tmr_ld = 1'b0; tmr_val = '0; poll_go = 1'b0; buf_we = 1'b0;
    fl_we = 1'b0; fl_re = poll_re; fl_addr = poll_rd_addr; fl_wdata = '0;
    src_ready = 1'b0; done = 1'b0;
    case (st_q)
      S_IDLE: if (acc) begin
        op_d    = op_e'(req_op);
        tgt_d   = req_addr;
        len_d   = (op_e'(req_op) == OP_PAGE) ? req_len : LENW'(1);
        idx_d   = '0;
        step_d  = '0;
        tries_d = '0;
        fail_d  = 1'b0;
        st_d    = op_is_prog(op_e'(req_op)) ? S_LOAD : S_CMD;
      end
      S_LOAD: begin
        src_ready = 1'b1;
        if (src_valid) begin
          buf_we = 1'b1;
          if (last_idx) begin
            idx_d = '0;
            st_d  = ((op_q == OP_BYTE) && (src_data == ERASED)) ? S_FIN : S_CMD;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      S_CMD: begin
        fl_we = 1'b1; fl_addr = tbl_addr; fl_wdata = tbl_data;
        if (tbl_last) begin
          step_d = '0;
          if (op_is_prog(op_q)) begin
            idx_d = '0; st_d = S_DATA;
          end else begin
            tmr_ld  = 1'b1;
            tmr_val = op_is_erase(op_q) ? TW'(GAP_CYC) : TW'(PROT_CYC);
            st_d    = S_HOLD;
          end
        end else begin
          step_d = step_q + 3'd1;
          if (op_is_erase(op_q)) begin
            tmr_ld = 1'b1; tmr_val = TW'(GAP_CYC); st_d = S_HOLD;
          end
        end
      end
      S_HOLD: if (tmr_last) begin
        if (step_q != '0)              st_d = S_CMD;
        else if (op_is_erase(op_q)) begin poll_go = 1'b1; st_d = S_POLL; end
        else                           st_d = S_FIN;
      end
      S_DATA: begin
        if (buf_rdata != ERASED) begin
          fl_we = 1'b1; fl_addr = data_addr; fl_wdata = buf_rdata;
        end
        if (last_idx) begin
          idx_d = '0; poll_go = 1'b1; st_d = S_POLL;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      S_POLL: if (poll_fin) begin
        if (poll_to)                fail_d = 1'b1;
        if (!poll_to && op_is_prog(op_q)) begin idx_d = '0; st_d = S_VRD; end
        else                        st_d = S_FIN;
      end
      S_VRD: begin
        fl_re = 1'b1; fl_addr = data_addr; st_d = S_VCAP;
      end
      S_VCAP: begin
        if (fl_rdata != buf_rdata) begin
          if (tries_q < RW'(MAX_RETRY)) begin
            tries_d = tries_q + RW'(1); idx_d = '0; step_d = '0; st_d = S_CMD;
          end else begin
            fail_d = 1'b1; st_d = S_FIN;
          end
        end else if (last_idx) begin
          st_d = S_FIN;
        end else begin
          idx_d = idx_q + IW'(1); st_d = S_VRD;
        end
      end
      S_FIN: begin
        done = 1'b1; st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_SECT; tgt_q <= '0; len_q <= '0; idx_q <= '0;
      step_q <= '0; tries_q <= '0; fail_q <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; tgt_q <= tgt_d; len_q <= len_d; idx_q <= idx_d;
      step_q <= step_d; tries_q <= tries_d; fail_q <= fail_d;
    end
  end

  assign busy = (st_q != S_IDLE);
  assign fail = fail_q;

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(fl_we && fl_re)); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done); // R11

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (fail && !(req_valid && !busy)) |=> fail); // R11

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !done) |=> busy); // R3

  AST_TRIES_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    tries_q <= RW'(MAX_RETRY)); // R10

  AST_SRC_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    src_ready |-> (busy && !fl_we && !fl_re)); // R12

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

  localparam int            AW    = 20;
  localparam logic [19:0]   BASE  = 20'h40000;
  localparam int            PMAX  = 16;
  localparam int            GAP   = 4;
  localparam int            PROT  = 20;
  localparam int            POLLM = 40;
  localparam int            RETRY = 3;
  localparam int            LENW  = 5;
  localparam int            TOG   = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, src_valid, src_ready, fl_we, fl_re, busy, done, fail;
  logic [2:0]      req_op;
  logic [AW-1:0]   req_addr, fl_addr;
  logic [LENW-1:0] req_len;
  logic [7:0]      src_data, fl_wdata, fl_rdata;

  flash_cmd_seq #(.AW(AW), .BASE(BASE), .PAGE_MAX(PMAX), .GAP_CYC(GAP),
                  .PROT_CYC(PROT), .POLL_MAX(POLLM), .MAX_RETRY(RETRY)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .fl_we(fl_we), .fl_re(fl_re),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .busy(busy), .done(done), .fail(fail)
  );

  // flash model and bus monitor
  int          cyc = 0, log_n = 0, rd_n = 0, rd_first = 0, done_n = 0, done_c = 0, src_n = 0;
  logic [19:0] log_a [0:127];
  int          log_d [0:127];
  int          log_c [0:127];
  logic [7:0]  mem [0:255];
  int          tog_left = 0, drop_n = 0;
  logic        tog_v = 1'b0, prog_md = 1'b0, tog_force = 1'b0;
  logic [19:0] off;

  initial begin
    fl_rdata = 8'h00;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  end

  always @(posedge clk) begin
    off = fl_addr - BASE;
    if (fl_we) begin
      if (log_n < 128) begin
        log_a[log_n] = fl_addr; log_d[log_n] = int'(fl_wdata); log_c[log_n] = cyc;
      end
      log_n++;
      if (off == 20'h05555 || off == 20'h02AAA) begin
        if (fl_wdata == 8'hAA) prog_md = 1'b0;
        else if (fl_wdata == 8'hA0) prog_md = 1'b1;
        else if (fl_wdata == 8'h10) begin
          for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
          tog_left = TOG;
        end
      end else if (prog_md) begin
        if (drop_n > 0) drop_n--;
        else mem[off[7:0]] = fl_wdata;
        tog_left = TOG;
      end else if (fl_wdata == 8'h30 || fl_wdata == 8'h50) begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        tog_left = TOG;
      end
    end
    if (fl_re) begin
      if (rd_n == 0) rd_first = cyc;
      rd_n++;
      if (tog_force || tog_left > 0) begin
        tog_v = ~tog_v;
        fl_rdata <= {1'b0, tog_v, 6'b0};
        if (tog_left > 0) tog_left--;
      end else begin
        fl_rdata <= mem[off[7:0]];
      end
    end
    if (done) begin done_n++; done_c = cyc; end
    if (src_valid && src_ready) src_n++;
    cyc++;
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic clr();
    log_n = 0; rd_n = 0; done_n = 0; src_n = 0;
  endtask

  task automatic send_req(input int op, input int addr, input int len);
    req_valid = 1'b1; req_op = 3'(op); req_addr = 20'(addr); req_len = 5'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    src_valid = 1'b1; src_data = b;
    while (!src_ready) @(negedge clk);
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic wait_done(input string r);
    int guard = 0;
    while (done_n == 0 && guard < 20000) begin @(negedge clk); guard++; end
    check({r, " completion"}, int'(done_n != 0), 1);
  endtask

  task automatic chk_wr(input string r, input int k, input int a, input int d);
    check({r, " addr"}, int'(log_a[k]), a);
    check({r, " data"}, log_d[k], d);
  endtask

  task automatic chk_prefix6(input string r);
    chk_wr(r, 0, BASE + 20'h5555, 8'hAA);
    chk_wr(r, 1, BASE + 20'h2AAA, 8'h55);
    chk_wr(r, 2, BASE + 20'h5555, 8'h80);
    chk_wr(r, 3, BASE + 20'h5555, 8'hAA);
    chk_wr(r, 4, BASE + 20'h2AAA, 8'h55);
  endtask

  task automatic chk_prefix3(input string r, input int k0);
    chk_wr(r, k0,     BASE + 20'h5555, 8'hAA);
    chk_wr(r, k0 + 1, BASE + 20'h2AAA, 8'h55);
    chk_wr(r, k0 + 2, BASE + 20'h5555, 8'hA0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    check("R1 fl_we", int'(fl_we), 0);
    check("R1 fl_re", int'(fl_re), 0);
    check("R1 src_ready", int'(src_ready), 0);
  endtask

  task automatic t_erase(input int op, input int tgt, input int fa, input int fd, input string r);
    clr();
    send_req(op, tgt, 0);
    check({r, " R3 accepted"}, int'(busy), 1);
    wait_done(r);
    check({r, " R4 write count"}, log_n, 6);
    chk_prefix6({r, " R4"});
    chk_wr({r, " R4 final"}, 5, fa, fd);
    for (int k = 0; k < 5; k++)
      check({r, " R5 gap"}, log_c[k + 1] - log_c[k], GAP + 1);
    check({r, " R5 first poll read"}, rd_first - log_c[5], GAP + 1);
    check({r, " R6 no fail"}, int'(fail), 0);
    check({r, " R11 single done"}, done_n, 1);
  endtask

  task automatic t_unprot();
    clr();
    send_req(6, 0, 0);
    wait_done("R7 unprotect");
    check("R7 unprotect count", log_n, 6);
    chk_prefix6("R7 unprotect");
    chk_wr("R7 unprotect final", 5, BASE + 20'h5555, 8'h20);
    check("R7 unprotect no reads", rd_n, 0);
    check("R7 unprotect wait", done_c - log_c[5], PROT + 1);
  endtask

  task automatic t_prot();
    clr();
    send_req(5, 0, 0);
    wait_done("R7 protect");
    check("R7 protect count", log_n, 3);
    chk_prefix3("R7 protect", 0);
    check("R7 protect no reads", rd_n, 0);
    check("R7 protect wait", done_c - log_c[2], PROT + 1);
  endtask

  task automatic t_byte();
    clr();
    send_req(3, 20'h123, 0);
    feed(8'h3C);
    wait_done("R8 byte");
    check("R8 byte count", log_n, 4);
    chk_prefix3("R8 byte", 0);
    chk_wr("R8 byte data", 3, BASE + 20'h123, 8'h3C);
    check("R10 R13 byte readback ok", int'(fail), 0);
    check("R8 byte stored", int'(mem[8'h23]), 8'h3C);
    check("R12 byte one taken", src_n, 1);
  endtask

  task automatic t_byte_ff();
    clr();
    send_req(3, 20'h124, 0);
    feed(8'hFF);
    wait_done("R8 erased byte");
    check("R8 erased byte no writes", log_n, 0);
    check("R8 erased byte no fail", int'(fail), 0);
  endtask

  task automatic t_page();
    logic [7:0] pg [0:4];
    pg[0] = 8'h11; pg[1] = 8'hFF; pg[2] = 8'h22; pg[3] = 8'hFF; pg[4] = 8'h33;
    clr();
    send_req(4, 20'h040, 5);
    check("R12 ready while loading", int'(src_ready), 1);
    for (int i = 0; i < 5; i++) feed(pg[i]);
    check("R12 ready drops", int'(src_ready), 0);
    wait_done("R9 page");
    check("R12 page bytes taken", src_n, 5);
    check("R9 page write count", log_n, 6);
    chk_prefix3("R9 page", 0);
    chk_wr("R9 page b0", 3, BASE + 20'h040, 8'h11);
    chk_wr("R9 page b2", 4, BASE + 20'h042, 8'h22);
    chk_wr("R9 page b4", 5, BASE + 20'h044, 8'h33);
    check("R10 page verify ok", int'(fail), 0);
  endtask

  task automatic t_retry_ok();
    clr();
    drop_n = 2;
    send_req(3, 20'h060, 0);
    feed(8'h5A);
    wait_done("R10 retry");
    check("R10 retry writes", log_n, 12);
    check("R10 retry recovers", int'(fail), 0);
    check("R10 retry stored", int'(mem[8'h60]), 8'h5A);
  endtask

  task automatic t_retry_fail();
    clr();
    drop_n = 1000;
    send_req(3, 20'h061, 0);
    feed(8'h77);
    wait_done("R10 exhaust");
    check("R10 exhaust writes", log_n, 4 * (RETRY + 1));
    check("R10 exhaust fail", int'(fail), 1);
    drop_n = 0;
    repeat (10) @(negedge clk);
    check("R11 fail sticky", int'(fail), 1);
  endtask

  task automatic t_refuse();
    send_req(7, 0, 0);
    check("R2 code 7 refused", int'(busy), 0);
    send_req(4, 20'h080, 0);
    check("R2 zero length refused", int'(busy), 0);
    send_req(4, 20'h080, PMAX + 1);
    check("R2 long page refused", int'(busy), 0);
    check("R11 refused keeps fail", int'(fail), 1);
    check("R2 refused no writes", int'(fl_we), 0);
    clr();
    send_req(5, 0, 0);
    check("R11 accept clears fail", int'(fail), 0);
    wait_done("R11 after clear");
  endtask

  task automatic t_overlap();
    int guard = 0;
    clr();
    req_valid = 1'b1; req_op = 3'd5; req_addr = '0; req_len = '0;
    while (done_n == 0 && guard < 2000) begin @(negedge clk); guard++; end
    check("R3 held request ignored while busy", log_n, 3);
    check("R3 idle after done", int'(busy), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 taken after idle", int'(busy), 1);
    done_n = 0;
    wait_done("R3 second op");
    check("R3 second sequence", log_n, 6);
    chk_prefix3("R3 second", 3);
  endtask

  task automatic t_timeout();
    clr();
    tog_force = 1'b1;
    send_req(0, 20'h200, 0);
    wait_done("R6 timeout");
    tog_force = 1'b0;
    check("R6 timeout reads", rd_n, POLLM);
    check("R6 timeout fail", int'(fail), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0;
    src_valid = 1'b0; src_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_erase(0, 20'h01200, BASE + 20'h01200, 8'h30, "sector");
    t_erase(1, 20'h08000, BASE + 20'h08000, 8'h50, "block");
    t_erase(2, 20'h00000, BASE + 20'h05555, 8'h10, "chip");
    t_unprot();
    t_prot();
    t_byte();
    t_byte_ff();
    t_page();
    t_retry_ok();
    t_retry_fail();
    t_refuse();
    t_overlap();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule